// File: doc/BRIEF.md
# EPROM Byte Program-Verify Sequencer

This controller sits on the programmer side of a parallel, electrically programmed read-only memory and writes a contiguous address range into it. A start pulse supplies the first and last address. Bytes to be written arrive one at a time on a ready/valid input, in ascending address order. For each byte the controller reads the target cell first, then applies a loop of chip-enable program pulses. Every pulse is followed by a verify read. A byte gets at most a fixed number of pulses. The controller drives address, write data and its bus enable, chip enable, output enable, the programming-voltage enable and a two-bit supply-level select. It compares the data read back against the requested byte.

When the last address has been programmed, the programming voltage is removed and the whole range is read back twice: first at a raised check supply, then at a lowered check supply. For each of these two passes the source sends the expected bytes again through the same handshake, so no copy of the range is kept inside the block. All durations are parameters counted in clock cycles. The result is reported as a held done or fail flag, together with the failing address and a two-bit code for the phase that failed. The range is assumed to satisfy end address ≥ start address.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset, chip enable and output enable are high, the write-data bus is released, the programming-voltage enable is low, the supply select is 2'b00, and done, fail and in_ready are low.
- R2: A start pulse accepted while idle, done or failed raises the programming-voltage enable and sets the supply select to 2'b01 (program level) at once. The block then waits T_PWR cycles with chip enable high before it raises in_ready for the first byte. A start pulse during a run is ignored.
- R3: Each byte is read before any pulse is applied. If the target holds a zero where the requested byte has a one, the run fails with phase code 2'b00 at that address and no pulse is issued. If the target already equals the requested byte, no pulse is issued for it.
- R4: A program pulse holds chip enable low with output enable high for exactly T_PW cycles. Throughout the pulse the programming voltage is on at select 2'b01. The write data has been driven, with the address stable, for at least T_AS cycles before chip enable falls.
- R5: After each pulse the write data stays driven for T_DH cycles with chip enable high. It is then released, and T_OES further cycles pass before output enable falls for the verify read. The bus is never driven while output enable is low.
- R6: A verify read follows every pulse. A byte that needs k pulses, with k ≤ MAX_PULSES, receives exactly k. The pulse count restarts at every new address.
- R7: If a byte still fails verify after MAX_PULSES pulses, the run fails with phase code 2'b01 at that address and no further pulse is issued.
- R8: After the last address passes, the programming voltage is switched off and the range is read once at select 2'b10 (high check), then once at select 2'b11 (low check). Every address from start to end is read in each pass, with its expected byte taken again through the ready/valid input.
- R9: A mismatch in the final check fails the run with phase code 2'b10 (high check) or 2'b11 (low check) and the mismatching address.
- R10: On success done is held, and on failure fail is held, together with the failing address and phase. In both cases supplies are off and chip enable and output enable are high, until the next accepted start clears the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (one-cycle pulse) |
| start_addr | input | AW | First address of the range |
| end_addr | input | AW | Last address of the range |
| in_valid | input | 1 | Source offers a byte |
| in_data | input | DW | Requested byte for the current address |
| in_ready | output | 1 | Block takes a byte this cycle when in_valid is high |
| mem_addr | output | AW | Address to the memory |
| mem_wdata | output | DW | Data to the memory |
| mem_wdata_oe | output | 1 | Drive mem_wdata onto the data bus |
| mem_rdata | input | DW | Data read from the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| vpp_en | output | 1 | Programming-voltage enable |
| vcc_sel | output | 2 | Supply level: 00 nominal, 01 program, 10 high check, 11 low check |
| done | output | 1 | Run finished with every check passed |
| fail | output | 1 | Run stopped on an error |
| fail_addr | output | AW | Address at which the run failed |
| fail_phase | output | 2 | 00 blocked bit, 01 pulse limit, 10 high check, 11 low check |

## Verification
The assertions watch the memory pins on every cycle. They check the exact pulse width and the setup count before each pulse, and they check that the supplies are correct during a pulse. They also check the hold and release spacing before a verify read, the absence of bus contention, the cap on pulses per address, and that the programming voltage is off in the final passes and while the status is held. The directed scenarios run a behavioural memory that needs a chosen number of pulses per address. Only these scenarios can show that bytes end up with the right contents and get exactly the right number of pulses. They also show that an unprogrammable byte is caught before pulsing, that the two final passes cover the whole range in order, and that the failing address and phase are reported correctly.

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq #(
  parameter int AW         = 19,
  parameter int DW         = 8,
  parameter int T_PWR      = 400,
  parameter int T_AS       = 400,
  parameter int T_PW       = 10000,
  parameter int T_DH       = 400,
  parameter int T_OES      = 400,
  parameter int T_RD       = 20,
  parameter int MAX_PULSES = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] end_addr,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_wdata_oe,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          vpp_en,
  output logic [1:0]    vcc_sel,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [1:0]    fail_phase
);
  localparam int TM1  = (T_PW > T_PWR) ? T_PW : T_PWR;
  localparam int TM2  = (TM1 > T_AS) ? TM1 : T_AS;
  localparam int TM3  = (TM2 > T_DH) ? TM2 : T_DH;
  localparam int TM4  = (TM3 > T_OES) ? TM3 : T_OES;
  localparam int TMAX = (TM4 > T_RD) ? TM4 : T_RD;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int PCW  = $clog2(MAX_PULSES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_PWR, S_FETCH, S_PRE, S_SETUP, S_PULSE, S_HOLD, S_RECOV,
    S_VER, S_FPWR, S_FFETCH, S_FRD, S_DONE, S_FAIL
  } st_t;

  st_t            st;
  logic [TW-1:0]  tmr;
  logic [PCW-1:0] npulse;
  logic [AW-1:0]  addr, first, last;
  logic [DW-1:0]  dq;
  logic           lo_pass;
  logic [AW-1:0]  fa_q;
  logic [1:0]     fp_q;

  wire tdone    = (tmr == '0);
  wire at_end   = (addr == last);
  wire rd_match = (mem_rdata == dq);
  wire blocked  = |(dq & ~mem_rdata);
  wire prog_ph  = (st == S_PWR) || (st == S_FETCH) || (st == S_PRE) || (st == S_SETUP) ||
                  (st == S_PULSE) || (st == S_HOLD) || (st == S_RECOV) || (st == S_VER);
  wire final_ph = (st == S_FPWR) || (st == S_FFETCH) || (st == S_FRD);
  wire reading  = (st == S_PRE) || (st == S_VER) || (st == S_FRD);

  assign in_ready     = (st == S_FETCH) || (st == S_FFETCH);
  assign mem_addr     = addr;
  assign mem_wdata    = dq;
  assign mem_wdata_oe = (st == S_SETUP) || (st == S_PULSE) || (st == S_HOLD);
  assign mem_ce_n     = !(reading || st == S_PULSE);
  assign mem_oe_n     = !reading;
  assign vpp_en       = prog_ph;
  assign vcc_sel      = prog_ph ? 2'b01 : final_ph ? {1'b1, lo_pass} : 2'b00;
  assign done         = (st == S_DONE);
  assign fail         = (st == S_FAIL);
  assign fail_addr    = fa_q;
  assign fail_phase   = fp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tmr     <= '0;
      npulse  <= '0;
      addr    <= '0;
      first   <= '0;
      last    <= '0;
      dq      <= '1;
      lo_pass <= 1'b0;
      fa_q    <= '0;
      fp_q    <= 2'b00;
    end else begin
      case (st)
        S_IDLE, S_DONE, S_FAIL: if (start) begin
          addr    <= start_addr;
          first   <= start_addr;
          last    <= end_addr;
          lo_pass <= 1'b0;
          fa_q    <= '0;
          fp_q    <= 2'b00;
          tmr     <= TW'(T_PWR - 1);
          st      <= S_PWR;
        end
        S_PWR: if (tdone) st <= S_FETCH; else tmr <= tmr - 1'b1;
        S_FETCH: if (in_valid) begin
          dq     <= in_data;
          npulse <= '0;
          tmr    <= TW'(T_RD - 1);
          st     <= S_PRE;
        end
        S_PRE, S_VER: if (!tdone) tmr <= tmr - 1'b1;
          else if (st == S_PRE && blocked) begin
            fa_q <= addr;
            fp_q <= 2'b00;
            st   <= S_FAIL;
          end else if (rd_match) begin
            if (at_end) begin
              addr <= first;
              tmr  <= TW'(T_PWR - 1);
              st   <= S_FPWR;
            end else begin
              addr <= addr + 1'b1;
              st   <= S_FETCH;
            end
          end else if (npulse == PCW'(MAX_PULSES)) begin
            fa_q <= addr;
            fp_q <= 2'b01;
            st   <= S_FAIL;
          end else begin
            tmr <= TW'(T_AS - 1);
            st  <= S_SETUP;
          end
        S_SETUP: if (tdone) begin
          npulse <= npulse + 1'b1;
          tmr    <= TW'(T_PW - 1);
          st     <= S_PULSE;
        end else tmr <= tmr - 1'b1;
        S_PULSE: if (tdone) begin
          tmr <= TW'(T_DH - 1);
          st  <= S_HOLD;
        end else tmr <= tmr - 1'b1;
        S_HOLD: if (tdone) begin
          tmr <= TW'(T_OES - 1);
          st  <= S_RECOV;
        end else tmr <= tmr - 1'b1;
        S_RECOV: if (tdone) begin
          tmr <= TW'(T_RD - 1);
          st  <= S_VER;
        end else tmr <= tmr - 1'b1;
        S_FPWR: if (tdone) st <= S_FFETCH; else tmr <= tmr - 1'b1;
        S_FFETCH: if (in_valid) begin
          dq  <= in_data;
          tmr <= TW'(T_RD - 1);
          st  <= S_FRD;
        end
        S_FRD: if (!tdone) tmr <= tmr - 1'b1;
          else if (!rd_match) begin
            fa_q <= addr;
            fp_q <= {1'b1, lo_pass};
            st   <= S_FAIL;
          end else if (!at_end) begin
            addr <= addr + 1'b1;
            st   <= S_FFETCH;
          end else if (lo_pass) begin
            st <= S_DONE;
          end else begin
            lo_pass <= 1'b1;
            addr    <= first;
            tmr     <= TW'(T_PWR - 1);
            st      <= S_FPWR;
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module eprom_prog_seq_chk #(
  parameter int AW         = 19,
  parameter int DW         = 8,
  parameter int T_AS       = 400,
  parameter int T_PW       = 10000,
  parameter int T_DH       = 400,
  parameter int T_OES      = 400,
  parameter int MAX_PULSES = 25
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_wdata_oe,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          vpp_en,
  input logic [1:0]    vcc_sel,
  input logic          in_ready,
  input logic          done,
  input logic          fail
);
  wire in_pulse = !mem_ce_n && mem_oe_n;
  logic          pulse_q, after_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;
  logic [31:0]   pw_cnt, su_cnt, ho_cnt, rc_cnt, np_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      after_q <= 1'b0;
      addr_q  <= '0;
      wd_q    <= '0;
      pw_cnt  <= '0;
      su_cnt  <= '0;
      ho_cnt  <= '0;
      rc_cnt  <= '0;
      np_cnt  <= '0;
    end else begin
      pulse_q <= in_pulse;
      addr_q  <= mem_addr;
      wd_q    <= mem_wdata;
      pw_cnt  <= in_pulse ? pw_cnt + 1 : '0;
      su_cnt  <= (mem_wdata_oe && mem_ce_n && mem_addr == addr_q && mem_wdata == wd_q) ? su_cnt + 1 : '0;
      ho_cnt  <= in_pulse ? '0 : (mem_wdata_oe ? ho_cnt + 1 : ho_cnt);
      rc_cnt  <= (!mem_wdata_oe && mem_ce_n && mem_oe_n) ? rc_cnt + 1 : '0;
      if (in_pulse) after_q <= 1'b1;
      else if (!mem_oe_n) after_q <= 1'b0;
      if (done || fail || mem_addr != addr_q) np_cnt <= '0;
      else if (in_pulse && !pulse_q) np_cnt <= np_cnt + 1;
    end
  end

  assert_pulse_supply_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_pulse |-> (vpp_en && vcc_sel == 2'b01 && mem_wdata_oe));
  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && !in_pulse) |-> (pw_cnt == 32'(T_PW)));
  assert_pulse_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pulse && !pulse_q) |-> (su_cnt >= 32'(T_AS)));
  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wdata_oe) |-> (ho_cnt >= 32'(T_DH)));
  assert_verify_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_oe_n) && after_q) |-> (rc_cnt >= 32'(T_OES)));
  assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wdata_oe && !mem_oe_n));
  assert_pulse_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    np_cnt <= 32'(MAX_PULSES));
  assert_final_vpp_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_sel[1] |-> !vpp_en);
  assert_status_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fail, in_ready, !mem_ce_n}));
  assert_status_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> (!vpp_en && vcc_sel == 2'b00 && mem_ce_n && mem_oe_n && !mem_wdata_oe));
endmodule

bind eprom_prog_seq eprom_prog_seq_chk #(
  .AW(AW), .DW(DW), .T_AS(T_AS), .T_PW(T_PW), .T_DH(T_DH), .T_OES(T_OES),
  .MAX_PULSES(MAX_PULSES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_wdata_oe(mem_wdata_oe), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
  .vpp_en(vpp_en), .vcc_sel(vcc_sel), .in_ready(in_ready), .done(done), .fail(fail)
);

// File: tb/eprom_prog_seq_tb.sv
module eprom_prog_seq_tb;
  localparam int AW = 4, DW = 8;
  localparam int T_PWR = 6, T_AS = 4, T_PW = 10, T_DH = 3, T_OES = 3, T_RD = 2, MAXP = 6;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
  logic [AW-1:0] start_addr = '0, end_addr = '0;
  logic [DW-1:0] in_data = '0, mem_rdata;
  logic in_ready, mem_wdata_oe, mem_ce_n, mem_oe_n, vpp_en, done, fail;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [DW-1:0] mem_wdata;
  logic [1:0] vcc_sel, fail_phase;

  always #2.5 clk = ~clk;

  eprom_prog_seq #(.AW(AW), .DW(DW), .T_PWR(T_PWR), .T_AS(T_AS), .T_PW(T_PW), .T_DH(T_DH),
    .T_OES(T_OES), .T_RD(T_RD), .MAX_PULSES(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .end_addr(end_addr),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe), .mem_rdata(mem_rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .vpp_en(vpp_en), .vcc_sel(vcc_sel),
    .done(done), .fail(fail), .fail_addr(fail_addr), .fail_phase(fail_phase));

  // behavioural memory
  logic [DW-1:0] arr [16];
  logic [DW-1:0] want [16];
  int need [16];
  int pcnt [16];
  logic weak_on = 1'b0;
  logic [AW-1:0] weak_a = '0;
  logic [1:0] weak_sel = 2'b00;
  assign mem_rdata = (weak_on && mem_addr == weak_a && vcc_sel == weak_sel) ?
                     (arr[mem_addr] ^ 8'h01) : arr[mem_addr];

  int nchk = 0, nfail = 0, terr = 0, rd_hi = 0, rd_lo = 0, cyc = 0, stall = 0;
  int pwc = 0, scnt = 0, hcnt = 0, rcnt = 0;
  logic pul_q = 1'b0, after = 1'b0, oe_q = 1'b1, feed = 1'b0;

  always @(negedge clk) begin
    automatic logic cur = !mem_ce_n && mem_oe_n;
    if (cur && !pul_q) begin
      if (scnt != T_AS) terr++;
      if (!vpp_en) terr++;
      pwc = 0; after = 1'b1; hcnt = 0; rcnt = 0; scnt = 0;
    end
    if (cur) pwc++;
    if (pul_q && !cur) begin
      if (pwc != T_PW) terr++;
      pcnt[mem_addr]++;
      need[mem_addr]--;
      if (need[mem_addr] <= 0) arr[mem_addr] = arr[mem_addr] & mem_wdata;
    end
    if (!cur && after) begin
      if (!mem_oe_n) begin
        if (hcnt != T_DH || rcnt != T_OES) terr++;
        after = 1'b0;
      end else if (mem_wdata_oe) hcnt++;
      else rcnt++;
    end else if (!cur && !after) begin
      if (mem_wdata_oe) scnt++; else scnt = 0;
    end
    if (!mem_oe_n && oe_q) begin
      if (vcc_sel == 2'b10) begin rd_hi++; if (rd_lo > 0) terr++; end
      if (vcc_sel == 2'b11) rd_lo++;
    end
    oe_q = mem_oe_n;
    pul_q = cur;
    stall++;
    in_valid <= feed && (stall % 3 != 2);
    in_data  <= want[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int a = 0; a < 16; a++) begin
      arr[a] = 8'hFF; want[a] = 8'hFF; need[a] = 1; pcnt[a] = 0;
    end
    terr = 0; rd_hi = 0; rd_lo = 0; weak_on = 1'b0;
  endtask

  task automatic kick(input int s, input int e);
    @(negedge clk);
    start_addr = AW'(s); end_addr = AW'(e); start = 1'b1; feed = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!done && !fail && n < 20000) begin @(negedge clk); n++; end
    feed = 1'b0;
  endtask

  task automatic t_reset();
    chk(mem_ce_n && mem_oe_n && !mem_wdata_oe, "R1", "pins idle", {mem_ce_n, mem_oe_n, mem_wdata_oe}, 3'b110);
    chk(!vpp_en && vcc_sel == 2'b00, "R1", "supplies off", {vpp_en, vcc_sel}, 0);
    chk(!done && !fail && !in_ready, "R1", "status clear", {done, fail, in_ready}, 0);
  endtask

  task automatic t_program_ok();
    int cnt = 0;
    bit ce_seen = 0;
    init_mem();
    for (int a = 2; a <= 9; a++) begin
      want[a] = DW'(8'h5A ^ (a * 17));
      need[a] = a % 3 + 1;
    end
    want[4] = 8'hFF;
    need[6] = MAXP;
    kick(2, 9);
    chk(vpp_en && vcc_sel == 2'b01, "R2", "supply raised on start", {vpp_en, vcc_sel}, 3'b101);
    while (!in_ready && cnt < 100) begin
      if (!mem_ce_n) ce_seen = 1;
      cnt++; @(negedge clk);
    end
    chk(cnt == T_PWR && !ce_seen, "R2", "supply settle cycles", cnt, T_PWR);
    @(negedge clk);
    start_addr = 4'd0; end_addr = 4'd15; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_end();
    chk(done && !fail, "R10", "done held", {done, fail}, 2);
    chk(!vpp_en && vcc_sel == 2'b00, "R10", "supplies off at done", {vpp_en, vcc_sel}, 0);
    for (int a = 2; a <= 9; a++) begin
      if (a != 4) begin
        chk(arr[a] == want[a], "R6", "programmed byte", int'(arr[a]), int'(want[a]));
        chk(pcnt[a] == a % 3 + 1 || (a == 6 && pcnt[a] == MAXP), "R6", "pulse count", pcnt[a],
            (a == 6) ? MAXP : a % 3 + 1);
      end
    end
    chk(pcnt[4] == 0, "R3", "no pulse on matching byte", pcnt[4], 0);
    chk(pcnt[0] == 0 && pcnt[15] == 0 && arr[15] == 8'hFF, "R2", "restart ignored", pcnt[0] + pcnt[15], 0);
    chk(terr == 0, "R4", "pulse width/setup/supply", terr, 0);
    chk(terr == 0, "R5", "hold and verify spacing", terr, 0);
    chk(rd_hi == 8 && rd_lo == 8, "R8", "final pass reads", rd_hi * 100 + rd_lo, 808);
  endtask

  task automatic t_blocked();
    init_mem();
    for (int a = 3; a <= 7; a++) want[a] = 8'h3C;
    arr[5] = 8'h0F; want[5] = 8'hF0;
    kick(3, 7);
    wait_end();
    chk(fail && fail_phase == 2'b00 && fail_addr == 4'd5, "R3", "blocked byte fail",
        {fail, fail_phase, fail_addr}, {1'b1, 2'b00, 4'd5});
    chk(pcnt[5] == 0, "R3", "no pulse on blocked byte", pcnt[5], 0);
    chk(arr[4] == 8'h3C, "R6", "earlier byte programmed", int'(arr[4]), 8'h3C);
  endtask

  task automatic t_limit();
    init_mem();
    for (int a = 1; a <= 3; a++) want[a] = 8'h81;
    need[2] = MAXP + 1;
    kick(1, 3);
    wait_end();
    chk(fail && fail_phase == 2'b01 && fail_addr == 4'd2, "R7", "pulse limit fail",
        {fail, fail_phase, fail_addr}, {1'b1, 2'b01, 4'd2});
    chk(pcnt[2] == MAXP && pcnt[3] == 0, "R7", "pulses stop at cap", pcnt[2] * 10 + pcnt[3], MAXP * 10);
    chk(!vpp_en && mem_ce_n, "R10", "quiet after fail", {vpp_en, mem_ce_n}, 1);
  endtask

  task automatic t_final(input logic [1:0] sel, input int wa);
    init_mem();
    for (int a = 6; a <= 9; a++) want[a] = 8'hC3;
    weak_on = 1'b1; weak_a = AW'(wa); weak_sel = sel;
    kick(6, 9);
    wait_end();
    chk(fail && fail_phase == sel && fail_addr == AW'(wa), "R9", "final check fail",
        {fail, fail_phase, fail_addr}, {1'b1, sel, AW'(wa)});
    if (sel == 2'b11) chk(rd_hi == 4, "R8", "high pass completed first", rd_hi, 4);
    else chk(rd_lo == 0, "R8", "low pass not started", rd_lo, 0);
  endtask

  task automatic t_restart();
    init_mem();
    want[0] = 8'hA5; need[0] = 2;
    kick(0, 0);
    chk(!fail && fail_phase == 2'b00, "R10", "start clears status", {fail, fail_phase}, 0);
    wait_end();
    chk(done && !fail && arr[0] == 8'hA5 && pcnt[0] == 2, "R10", "rerun succeeds", pcnt[0], 2);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    init_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program_ok();
    t_blocked();
    t_limit();
    t_final(2'b10, 7);
    t_final(2'b11, 8);
    t_restart();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule